// File: doc/BRIEF.md
# Pipelined Double-Precision Multiplier

This block multiplies two 64-bit binary floating-point numbers in the common double format: 1 sign bit, an 11-bit biased exponent with bias 1023, and a 52-bit fraction with a hidden leading one. A new operand pair may be presented on every clock. Each product leaves the pipeline a fixed number of cycles later, so a stream of back-to-back operations yields one result per cycle and needs no flow control. The `enable` input marks which cycles carry real operands, and `prod_valid` marks the matching results.

The arithmetic is kept deliberately simple. The significand product is cut off rather than rounded. Operands whose exponent field is zero are taken as zero. Any operand whose exponent field is all ones, whether infinity or NaN, makes the result infinity. A result whose exponent leaves the normal range collapses to signed zero or signed infinity. These rules make the block suitable for streaming datapaths that can accept truncation error and do not need exception flags.

Top module: `dpmul_top`

## Requirements
- R1: `prod_valid` follows `enable` through exactly 18 register stages. Operands sampled at rising edge N produce a product that is visible right after rising edge N+17.
- R2: Operands accepted on consecutive cycles produce results on consecutive cycles, in the same order, with no gaps and no interference between them.
- R3: The 52-bit result fraction is the normalized 106-bit significand product with every bit below the kept field dropped. No rounding is ever applied.
- R4: If either exponent field (bits 62:52) is 2047, the result is infinity: exponent field 2047 and fraction 0. This rule takes priority over every other rule, including a zero operand.
- R5: If neither operand is special and either exponent field is 0, the result is zero in bits 62:0. Denormal operands count as zero.
- R6: Result bit 63 is the XOR of the two operand sign bits. This applies to zero and infinity results as well as normal ones.
- R7: For two normal operands, the exponent is expA + expB − 1023. It is one higher when bit 105 of the significand product is set, and the fraction is then taken from product bits 104:53; otherwise it is taken from bits 103:52.
- R8: A normal-case exponent below 1 gives a signed zero. An exponent of exactly 1 is still returned as a normal number.
- R9: A normal-case exponent above 2046 gives a signed infinity. An exponent of exactly 2046 is still returned as a normal number.
- R10: While `prod_valid` is low, `prod` is all zeros. Both outputs are zero straight after reset.
- R11: A synchronous reset discards every operation in flight. None of them produces a valid result afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Operand pair on `op_a`/`op_b` is valid this cycle |
| op_a | input | 64 | First operand, double format |
| op_b | input | 64 | Second operand, double format |
| prod | output | 64 | Product, double format, zero when not valid |
| prod_valid | output | 1 | `prod` holds a result this cycle |

## Verification
The checker follows the sign, special-value, zero and pure-power-of-two properties of the operands on every cycle. Its properties are gated by `prod_valid`, so they assume only that `op_a` and `op_b` are known whenever `enable` is high, and that reset is asserted from time zero. The stimulus always drives defined operand values, including during idle cycles and reset. It changes inputs only on the falling clock edge and starts with reset held for several cycles. Directed pairs sit on each exponent boundary and on the special-value priority, while random pairs cover both narrow and full-range exponents with and without gaps in `enable`.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    localparam int W       = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int KEEP_W  = FRAC_W + 2;
    localparam int EXPC_W  = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;

    localparam logic [EXP_W-1:0]         EXP_ONES = '1;
    localparam logic signed [EXPC_W-1:0] EXP_LO   = 1;
    localparam logic signed [EXPC_W-1:0] EXP_HI   = (1 << EXP_W) - 2;

    typedef enum logic [1:0] {
        OPC_ZERO,
        OPC_NORM,
        OPC_SPEC
    } opcls_e;

    typedef struct packed {
        logic                     vld;
        logic                     sgn;
        logic                     is_inf;
        logic                     is_zero;
        logic signed [EXPC_W-1:0] exp;
    } meta_t;

    typedef struct packed {
        meta_t             meta;
        logic [SIG_W-1:0]  sig_a;
        logic [SIG_W-1:0]  sig_b;
        logic [PROD_W-1:0] acc;
    } mstage_t;

    typedef struct packed {
        meta_t             meta;
        logic [KEEP_W-1:0] top;
    } norm_in_t;

    function automatic opcls_e op_class(input logic [EXP_W-1:0] e);
        if (e == '0)
            return OPC_ZERO;
        if (e == EXP_ONES)
            return OPC_SPEC;
        return OPC_NORM;
    endfunction

    function automatic logic [W-1:0] pack_fp(input logic s,
                                             input logic [EXP_W-1:0] e,
                                             input logic [FRAC_W-1:0] f);
        return {s, e, f};
    endfunction

endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack
    import fmul_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         enable_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output mstage_t      s_o
);

    opcls_e  cls_a;
    opcls_e  cls_b;
    mstage_t nxt;

    always_comb begin
        cls_a            = op_class(a_i[W-2 -: EXP_W]);
        cls_b            = op_class(b_i[W-2 -: EXP_W]);
        nxt.meta.vld     = enable_i;
        nxt.meta.sgn     = a_i[W-1] ^ b_i[W-1];
        nxt.meta.is_inf  = (cls_a == OPC_SPEC) || (cls_b == OPC_SPEC);
        nxt.meta.is_zero = (cls_a == OPC_ZERO) || (cls_b == OPC_ZERO);
        nxt.meta.exp     = {2'b00, a_i[W-2 -: EXP_W]} + {2'b00, b_i[W-2 -: EXP_W]}
                           - EXPC_W'(BIAS);
        nxt.sig_a        = {1'b1, a_i[FRAC_W-1:0]};
        nxt.sig_b        = {1'b1, b_i[FRAC_W-1:0]};
        nxt.acc          = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            s_o <= '0;
        else
            s_o <= nxt;
    end

endmodule

// File: rtl/fmul_mant_pipe.sv
module fmul_mant_pipe
    import fmul_pkg::*;
#(
    parameter int CHUNK_W = 18,
    parameter int N_CHUNK = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  mstage_t  s_i,
    output norm_in_t n_o
);

    localparam int PP_W = SIG_W + CHUNK_W;

    for (genvar k = 0; k < N_CHUNK; k++) begin : g_stg
        mstage_t             d;
        logic [CHUNK_W-1:0]  chunk;
        logic [PP_W-1:0]     pp;
        logic [PROD_W-1:0]   sum;

        if (k == 0) begin : g_src
            assign d = s_i;
        end else begin : g_src
            assign d = g_stg[k-1].g_reg.q;
        end

        assign chunk = CHUNK_W'(d.sig_b >> (k * CHUNK_W));
        assign pp    = {{CHUNK_W{1'b0}}, d.sig_a} * {{SIG_W{1'b0}}, chunk};
        assign sum   = d.acc + (PROD_W'(pp) << (k * CHUNK_W));

        if (k < N_CHUNK - 1) begin : g_reg
            mstage_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q.meta  <= d.meta;
                    q.sig_a <= d.sig_a;
                    q.sig_b <= d.sig_b;
                    q.acc   <= sum;
                end
            end
        end else begin : g_reg
            norm_in_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q.meta <= d.meta;
                    q.top  <= KEEP_W'(sum >> (PROD_W - KEEP_W));
                end
            end
        end
    end

    assign n_o = g_stg[N_CHUNK-1].g_reg.q;

endmodule

// File: rtl/fmul_delay.sv
module fmul_delay #(
    parameter int  DEPTH = 1,
    parameter type T     = logic
) (
    input  logic clk,
    input  logic rst,
    input  T     d_i,
    output T     q_o
);

    if (DEPTH == 0) begin : g_thru
        assign q_o = d_i;
    end else begin : g_chain
        for (genvar k = 0; k < DEPTH; k++) begin : g_tap
            T prev;
            T q;
            if (k == 0) begin : g_in
                assign prev = d_i;
            end else begin : g_in
                assign prev = g_tap[k-1].q;
            end
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else
                    q <= prev;
            end
        end
        assign q_o = g_tap[DEPTH-1].q;
    end

endmodule

// File: rtl/fmul_pack.sv
module fmul_pack
    import fmul_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  norm_in_t     n_i,
    output logic [W-1:0] prod_o,
    output logic         vld_o
);

    logic                     hi;
    logic signed [EXPC_W-1:0] e_adj;
    logic [FRAC_W-1:0]        frac;
    logic [W-1:0]             res;

    always_comb begin
        hi    = n_i.top[KEEP_W-1];
        e_adj = n_i.meta.exp + $signed({{(EXPC_W-1){1'b0}}, hi});
        frac  = hi ? n_i.top[KEEP_W-2 -: FRAC_W] : n_i.top[KEEP_W-3 -: FRAC_W];
        if (!n_i.meta.vld)
            res = '0;
        else if (n_i.meta.is_inf)
            res = pack_fp(n_i.meta.sgn, EXP_ONES, '0);
        else if (n_i.meta.is_zero)
            res = pack_fp(n_i.meta.sgn, '0, '0);
        else if (e_adj < EXP_LO)
            res = pack_fp(n_i.meta.sgn, '0, '0);
        else if (e_adj > EXP_HI)
            res = pack_fp(n_i.meta.sgn, EXP_ONES, '0);
        else
            res = pack_fp(n_i.meta.sgn, e_adj[EXP_W-1:0], frac);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            prod_o <= res;
            vld_o  <= n_i.meta.vld;
        end
    end

endmodule

// File: rtl/dpmul_top.sv
module dpmul_top
    import fmul_pkg::*;
#(
    parameter int LATENCY = 18,
    parameter int CHUNK_W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic [63:0]  op_a,
    input  logic [63:0]  op_b,
    output logic [63:0]  prod,
    output logic         prod_valid
);

    localparam int N_CHUNK = (SIG_W + CHUNK_W - 1) / CHUNK_W;
    localparam int PAD     = LATENCY - 2 - N_CHUNK;

    if (PAD < 0) begin : g_bad_latency
        $error("LATENCY too small for the chosen CHUNK_W");
    end

    mstage_t  s_dec;
    norm_in_t n_mul;
    norm_in_t n_dly;

    fmul_unpack u_unpack (
        .clk      (clk),
        .rst      (rst),
        .enable_i (enable),
        .a_i      (op_a),
        .b_i      (op_b),
        .s_o      (s_dec)
    );

    fmul_mant_pipe #(
        .CHUNK_W (CHUNK_W),
        .N_CHUNK (N_CHUNK)
    ) u_mant (
        .clk (clk),
        .rst (rst),
        .s_i (s_dec),
        .n_o (n_mul)
    );

    fmul_delay #(
        .DEPTH (PAD),
        .T     (norm_in_t)
    ) u_pad (
        .clk (clk),
        .rst (rst),
        .d_i (n_mul),
        .q_o (n_dly)
    );

    fmul_pack u_pack (
        .clk    (clk),
        .rst    (rst),
        .n_i    (n_dly),
        .prod_o (prod),
        .vld_o  (prod_valid)
    );

endmodule

// File: rtl/fmul_checker.sv
module fmul_checker #(
    parameter int LATENCY = 18
) (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic [63:0] prod,
    input logic        prod_valid
);

    logic [LATENCY-1:0] vld_sr;
    logic [LATENCY-1:0] sgn_sr;
    logic [LATENCY-1:0] inf_sr;
    logic [LATENCY-1:0] zer_sr;
    logic [LATENCY-1:0] p2_sr;

    logic in_inf;
    logic in_zer;
    logic in_p2;

    assign in_inf = (&op_a[62:52]) || (&op_b[62:52]);
    assign in_zer = (op_a[62:52] == '0) || (op_b[62:52] == '0);
    assign in_p2  = (op_a[51:0] == '0) && (op_b[51:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sr <= '0;
            sgn_sr <= '0;
            inf_sr <= '0;
            zer_sr <= '0;
            p2_sr  <= '0;
        end else begin
            vld_sr <= {vld_sr[LATENCY-2:0], enable};
            sgn_sr <= {sgn_sr[LATENCY-2:0], op_a[63] ^ op_b[63]};
            inf_sr <= {inf_sr[LATENCY-2:0], in_inf};
            zer_sr <= {zer_sr[LATENCY-2:0], in_zer};
            p2_sr  <= {p2_sr[LATENCY-2:0], in_p2};
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        prod_valid == vld_sr[LATENCY-1]); // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !prod_valid |-> prod == 64'd0); // R10

    AST_NO_NAN_OUT: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && (&prod[62:52])) |-> prod[51:0] == 52'd0); // R4

    AST_INF_COLLAPSE: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && inf_sr[LATENCY-1]) |-> prod[62:0] == {11'h7FF, 52'd0}); // R4

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && zer_sr[LATENCY-1] && !inf_sr[LATENCY-1]) |-> prod[62:0] == 63'd0); // R5

    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
        prod_valid |-> prod[63] == sgn_sr[LATENCY-1]); // R6

    AST_POW2_FRAC: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && p2_sr[LATENCY-1]) |-> prod[51:0] == 52'd0); // R7

endmodule

bind dpmul_top fmul_checker #(.LATENCY(LATENCY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .op_a       (op_a),
    .op_b       (op_b),
    .prod       (prod),
    .prod_valid (prod_valid)
);

// File: tb/sim_dpmul_top.sv
module sim_dpmul_top;

    localparam int LAT = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [63:0] op_a = 64'd0;
    logic [63:0] op_b = 64'd0;
    logic [63:0] prod;
    logic        prod_valid;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    armed = 1'b0;
    string cur_tag = "";

    logic        m_v [LAT];
    logic [63:0] m_d [LAT];
    string       m_t [LAT];

    dpmul_top u0 (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .op_a       (op_a),
        .op_b       (op_b),
        .prod       (prod),
        .prod_valid (prod_valid)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b,
                                            output string tag);
        int           ea;
        int           eb;
        int           e;
        logic         s;
        logic [105:0] p;
        logic [51:0]  f;
        ea = int'(a[62:52]);
        eb = int'(b[62:52]);
        s  = a[63] ^ b[63];
        if (ea == 2047 || eb == 2047) begin
            tag = "R4";
            return {s, 11'h7FF, 52'd0};
        end
        if (ea == 0 || eb == 0) begin
            tag = "R5";
            return {s, 63'd0};
        end
        p = 106'({1'b1, a[51:0]}) * 106'({1'b1, b[51:0]});
        e = ea + eb - 1023;
        if (p[105]) begin
            e = e + 1;
            f = p[104:53];
        end else begin
            f = p[103:52];
        end
        if (e < 1) begin
            tag = "R8";
            return {s, 63'd0};
        end
        if (e > 2046) begin
            tag = "R9";
            return {s, 11'h7FF, 52'd0};
        end
        tag = "R7";
        return {s, e[10:0], f};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference pipeline: index 0 newest
    always @(posedge clk) begin
        string t;
        armed <= 1'b1;
        for (int i = LAT - 1; i > 0; i--) begin
            m_v[i] = m_v[i-1];
            m_d[i] = m_d[i-1];
            m_t[i] = m_t[i-1];
        end
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin
                m_v[i] = 1'b0;
                m_d[i] = 64'd0;
                m_t[i] = "R11";
            end
        end else begin
            m_v[0] = enable;
            if (enable) begin
                m_d[0] = ref_mul(op_a, op_b, t);
                m_t[0] = (cur_tag != "") ? cur_tag : t;
            end else begin
                m_d[0] = 64'd0;
                m_t[0] = "R10";
            end
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            chk("R1", {63'd0, prod_valid}, {63'd0, m_v[LAT-1]});
            chk(m_v[LAT-1] ? m_t[LAT-1] : "R10", prod, m_v[LAT-1] ? m_d[LAT-1] : 64'd0);
            if (m_v[LAT-1] && prod_valid)
                chk("R6", {63'd0, prod[63]}, {63'd0, m_d[LAT-1][63]});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected<=100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input string tag);
        @(negedge clk);
        enable  = 1'b1;
        op_a    = a;
        op_b    = b;
        cur_tag = tag;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            enable  = 1'b0;
            cur_tag = "";
            op_a    = {$urandom, $urandom};
            op_b    = {$urandom, $urandom};
        end
    endtask

    function automatic logic [63:0] mid_rand();
        logic [10:0] e;
        e = 11'(900 + ($urandom % 250));
        return {1'($urandom), e, 20'($urandom), $urandom};
    endfunction

    initial begin
        for (int i = 0; i < LAT; i++) begin
            m_v[i] = 1'b0;
            m_d[i] = 64'd0;
            m_t[i] = "R10";
        end
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // normalization with and without carry (R7)
        drive(64'h3FF0000000000000, 64'h3FF0000000000000, "R7");
        drive(64'h3FF8000000000000, 64'h3FF8000000000000, "R7");
        drive(64'h4000000000000000, 64'h4008000000000000, "R7");
        // truncation (R3)
        drive(64'h3FFFFFFFFFFFFFFF, 64'h3FFFFFFFFFFFFFFF, "R3");
        drive(64'h3FF0000000000001, 64'h3FFFFFFFFFFFFFFF, "R3");
        drive(64'h3FF5555555555555, 64'h4008000000000000, "R3");
        // sign (R6)
        drive(64'hC000000000000000, 64'h4008000000000000, "R6");
        drive(64'hC000000000000000, 64'hC008000000000000, "R6");
        idle(3);
        // special operands (R4)
        drive(64'h7FF0000000000000, 64'h4000000000000000, "R4");
        drive(64'h7FF8000000000001, 64'h3FF0000000000000, "R4");
        drive(64'h7FF0000000000000, 64'h0000000000000000, "R4");
        drive(64'hFFF0000000000000, 64'h4008000000000000, "R4");
        drive(64'h0000000000000005, 64'h7FFFFFFFFFFFFFFF, "R4");
        // zero and denormal (R5)
        drive(64'h0000000000000000, 64'h4014000000000000, "R5");
        drive(64'h0000000000000001, 64'h4008000000000000, "R5");
        drive(64'h8000000000000000, 64'h4000000000000000, "R5");
        drive(64'h000FFFFFFFFFFFFF, 64'hBFF0000000000000, "R5");
        // underflow boundary (R8)
        drive(64'h3FF0000000000000, 64'h0010000000000000, "R8");
        drive(64'h3FE0000000000000, 64'h0010000000000000, "R8");
        drive(64'h8010000000000000, 64'h0010000000000000, "R8");
        // overflow boundary (R9)
        drive(64'h3FF0000000000000, 64'h7FE0000000000000, "R9");
        drive(64'h4000000000000000, 64'hFFE0000000000000, "R9");
        drive(64'h3FF8000000000000, 64'h7FE0000000000000, "R9");
        drive(64'h7FE0000000000000, 64'h7FE0000000000000, "R9");
        idle(LAT + 2);

        // sustained back-to-back stream (R2)
        for (int i = 0; i < 60; i++)
            drive(mid_rand(), mid_rand(), "R2");
        idle(5);

        // random with gaps, full exponent range mixed with mid range
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 3) == 0) begin
                idle(1);
            end else if (($urandom % 2) == 0) begin
                drive(mid_rand(), mid_rand(), "");
            end else begin
                drive({$urandom, $urandom}, {$urandom, $urandom}, "");
            end
        end
        idle(LAT + 2);

        // reset with operations in flight (R11)
        for (int i = 0; i < 6; i++)
            drive(mid_rand(), mid_rand(), "");
        @(negedge clk);
        enable = 1'b0;
        rst    = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle(LAT + 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule